// File: doc/BRIEF.md
# Cache Line Refill Engine with Selectable Memory Organisation

This block is a cycle-accurate timing model of the memory side of a cache miss. A requester hands it a block address with a one-cycle start pulse. The engine then runs through the address phase, one or more bank-access phases and the word transfers. The completed line is returned as beats on a lane-addressed data bus, and a done pulse closes the refill. The memory organisation is chosen at build time:
- a memory one word wide;
- a memory two words wide;
- a memory four words wide;
- four one-word banks that start their access together and then hand over one word per bus cycle.

Each organisation gives its own fixed miss penalty.

Line storage is modelled as one small array per word lane, filled with a known pattern at reset. Lane i of the output bus always carries word i of the line. In the interleaved organisation, word i therefore comes from bank i. With the default timing, the address phase is 1 cycle, each access is 15 cycles and each transfer is 1 cycle. This gives 65, 33, 17 and 20 cycles for the four organisations.

Top module: `refill_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o and beat_vld_o are low, and beat_mask_o and beat_data_o are zero.
- R2: A start_i sampled high at a clock edge while the engine is idle is accepted. busy_o is high from that edge until the edge at which done_o rises, and busy_o is low while done_o is high.
- R3: In the one-word-wide organisation, done_o is high in exactly the cycle that follows the 65th clock edge after the accepting edge.
- R4: In the two-word-wide organisation, done_o follows the 33rd edge after acceptance.
- R5: In the four-word-wide organisation, done_o follows the 17th edge after acceptance.
- R6: In the interleaved organisation, done_o follows the 20th edge after acceptance. Words 0, 1, 2 and 3 appear alone after edges 17, 18, 19 and 20.
- R7: A beat's mask has one bit per word lane; bit i is set when word i is delivered in that beat. Beats appear as follows:
  - one-word-wide memory: word i appears after edge 1+16(i+1);
  - two-word-wide memory: words 2k and 2k+1 appear together after edge 1+16(k+1);
  - four-word-wide memory: all four words appear after edge 17.
- R8: Lane i of beat_data_o occupies bits [32i+31:32i]. Within a beat, a lane set in the mask carries 0x5A5A0000 + 4·(block address mod 16) + i. A lane not set in the mask carries zero.
- R9: A start_i that arrives while the engine is busy is ignored. It changes neither the line being returned nor the refill timing.
- R10: done_o is a one-cycle pulse that coincides with the beat carrying the last word of the line.
- R11: A start_i sampled in the cycle where done_o is high is accepted at once, so refills can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Refill request, sampled at the clock edge |
| blk_addr_i | input | ADDR_W | Line address of the refill |
| busy_o | output | 1 | A refill is in progress |
| beat_vld_o | output | 1 | A beat of line words is on the data bus |
| beat_mask_o | output | LINE_WORDS | Word lanes delivered in this beat |
| beat_data_o | output | LINE_WORDS*WORD_W | Line words, lane i holding word i |
| done_o | output | 1 | Last beat of the line; refill complete |

## Verification
The bench builds four copies of the engine side by side, one for each value of the organisation parameter. All four use the default timing of 1, 15 and 1 cycles and a 16-line store, and all four are driven by the same start and address stream. Because of this, the four penalties and beat patterns are checked against each other's stimulus. A start held high for hundreds of cycles makes each copy re-accept at its own done cycle, which tests the back-to-back and ignore-while-busy rules at four different phases. Addresses above 15 test the wrap of the line index.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW1 = 2'd0,
    ORG_WIDE2   = 2'd1,
    ORG_WIDE4   = 2'd2,
    ORG_IL4     = 2'd3
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS,
    ST_XFER
  } phase_e;

  // words delivered by one transfer for an organisation
  function automatic int unsigned org_width(org_e org, int unsigned words);
    case (org)
      ORG_WIDE2: return (words < 2) ? words : 2;
      ORG_WIDE4: return (words < 4) ? words : 4;
      default:   return 1;
    endcase
  endfunction

  // cycles from the accepting edge to the completing edge
  function automatic int unsigned refill_penalty(org_e org, int unsigned words,
                                                 int unsigned addr_c,
                                                 int unsigned acc_c,
                                                 int unsigned xfer_c);
    int unsigned beats;
    beats = words / org_width(org, words);
    if (org == ORG_IL4) return addr_c + acc_c + beats * xfer_c;
    return addr_c + beats * (acc_c + xfer_c);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // reset content of word 'lane' of stored line 'line'
  function automatic logic [31:0] seed_word(int unsigned line, int unsigned lane,
                                            int unsigned words);
    return 32'h5A5A_0000 + 32'(line * words + lane);
  endfunction

endpackage

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter org_e        ORG        = ORG_IL4,
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LINE_AW    = 4,
  parameter int unsigned ADDR_CYC   = 1,
  parameter int unsigned ACCESS_CYC = 15,
  parameter int unsigned XFER_CYC   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  blk_addr_i,
  output logic               busy_o,
  output logic               accept_o,
  output logic               xfer_end_o,
  output logic               last_beat_o,
  output logic [((LINE_WORDS/org_width(ORG, LINE_WORDS)) > 1 ?
                 $clog2(LINE_WORDS/org_width(ORG, LINE_WORDS)) : 1)-1:0] beat_idx_o,
  output logic [LINE_AW-1:0] line_o
);

  localparam int unsigned WPB     = org_width(ORG, LINE_WORDS);
  localparam int unsigned NBEATS  = LINE_WORDS / WPB;
  localparam int unsigned BEAT_W  = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam int unsigned CNT_MAX = max3(ADDR_CYC, ACCESS_CYC, XFER_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam bit          OVERLAP = (ORG == ORG_IL4);

  phase_e             state_q;
  logic [CNT_W-1:0]   rem_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [LINE_AW-1:0] line_q;

  phase_e             resume_state;
  logic [CNT_W-1:0]   resume_cnt;
  logic               phase_end;

  // after a non-final transfer: banks that overlap go straight to the next
  // word, the others open a fresh access
  generate
    if (OVERLAP) begin : g_overlap
      assign resume_state = ST_XFER;
      assign resume_cnt   = CNT_W'(XFER_CYC);
    end else begin : g_serial
      assign resume_state = ST_ACCESS;
      assign resume_cnt   = CNT_W'(ACCESS_CYC);
    end
  endgenerate

  assign accept_o    = (state_q == ST_IDLE) && start_i;
  assign phase_end   = (state_q != ST_IDLE) && (rem_q == CNT_W'(1));
  assign xfer_end_o  = (state_q == ST_XFER) && phase_end;
  assign last_beat_o = (beat_q == BEAT_W'(NBEATS - 1));
  assign busy_o      = (state_q != ST_IDLE);
  assign beat_idx_o  = beat_q;
  assign line_o      = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      beat_q  <= '0;
      line_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ADDR;
            rem_q   <= CNT_W'(ADDR_CYC);
            beat_q  <= '0;
            line_q  <= blk_addr_i[LINE_AW-1:0];
          end
        end
        ST_ADDR: begin
          if (phase_end) begin
            state_q <= ST_ACCESS;
            rem_q   <= CNT_W'(ACCESS_CYC);
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        ST_ACCESS: begin
          if (phase_end) begin
            state_q <= ST_XFER;
            rem_q   <= CNT_W'(XFER_CYC);
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: begin
          if (phase_end) begin
            if (last_beat_o) begin
              state_q <= ST_IDLE;
              rem_q   <= '0;
            end else begin
              state_q <= resume_state;
              rem_q   <= resume_cnt;
              beat_q  <= beat_q + 1'b1;
            end
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_AW    = 4,
  parameter int unsigned LANE       = 0,
  parameter int unsigned LINE_WORDS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_AW-1:0] rd_line_i,
  output logic [WORD_W-1:0]  rd_data_o
);

  localparam int unsigned DEPTH = 1 << LINE_AW;

  logic [WORD_W-1:0] mem_q [DEPTH];

  // contents are loaded with a known pattern at reset and never rewritten
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < DEPTH; d++) begin
        mem_q[d] <= WORD_W'(refill_pkg::seed_word(d, LANE, LINE_WORDS));
      end
    end
  end

  assign rd_data_o = mem_q[rd_line_i];

endmodule

// File: rtl/refill_beat.sv
module refill_beat #(
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned WPB        = 1,
  parameter int unsigned BEAT_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer_end_i,
  input  logic                         last_i,
  input  logic [BEAT_W-1:0]            beat_idx_i,
  input  logic [LINE_WORDS*WORD_W-1:0] lane_data_i,
  output logic                         beat_vld_o,
  output logic [LINE_WORDS-1:0]        beat_mask_o,
  output logic [LINE_WORDS*WORD_W-1:0] beat_data_o,
  output logic                         done_o
);

  logic [LINE_WORDS-1:0]        lane_hit;
  logic [LINE_WORDS*WORD_W-1:0] sel_data;

  generate
    for (genvar l = 0; l < LINE_WORDS; l++) begin : g_lane
      assign lane_hit[l] = (BEAT_W'(l / WPB) == beat_idx_i);
      assign sel_data[l*WORD_W +: WORD_W] =
        lane_hit[l] ? lane_data_i[l*WORD_W +: WORD_W] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_vld_o  <= 1'b0;
      beat_mask_o <= '0;
      beat_data_o <= '0;
      done_o      <= 1'b0;
    end else begin
      beat_vld_o  <= xfer_end_i;
      beat_mask_o <= xfer_end_i ? lane_hit : '0;
      beat_data_o <= xfer_end_i ? sel_data : '0;
      done_o      <= xfer_end_i && last_i;
    end
  end

endmodule

// File: rtl/refill_engine.sv
module refill_engine
  import refill_pkg::*;
#(
  parameter org_e        ORG         = ORG_IL4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned LINE_WORDS  = 4,
  parameter int unsigned DEPTH_LINES = 16,
  parameter int unsigned ADDR_CYC    = 1,
  parameter int unsigned ACCESS_CYC  = 15,
  parameter int unsigned XFER_CYC    = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [ADDR_W-1:0]            blk_addr_i,
  output logic                         busy_o,
  output logic                         beat_vld_o,
  output logic [LINE_WORDS-1:0]        beat_mask_o,
  output logic [LINE_WORDS*WORD_W-1:0] beat_data_o,
  output logic                         done_o
);

  localparam int unsigned LINE_AW = $clog2(DEPTH_LINES);
  localparam int unsigned WPB     = org_width(ORG, LINE_WORDS);
  localparam int unsigned NBEATS  = LINE_WORDS / WPB;
  localparam int unsigned BEAT_W  = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam int unsigned PENALTY =
    refill_penalty(ORG, LINE_WORDS, ADDR_CYC, ACCESS_CYC, XFER_CYC);

  // named internal events, visible to the bound checker
  logic                         accept_w;
  logic                         xfer_end_w;
  logic                         last_w;
  logic [BEAT_W-1:0]            beat_idx_w;
  logic [LINE_AW-1:0]           line_w;
  logic [LINE_WORDS*WORD_W-1:0] lane_data_w;

  refill_seq #(
    .ORG        (ORG),
    .LINE_WORDS (LINE_WORDS),
    .ADDR_W     (ADDR_W),
    .LINE_AW    (LINE_AW),
    .ADDR_CYC   (ADDR_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .XFER_CYC   (XFER_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .blk_addr_i  (blk_addr_i),
    .busy_o      (busy_o),
    .accept_o    (accept_w),
    .xfer_end_o  (xfer_end_w),
    .last_beat_o (last_w),
    .beat_idx_o  (beat_idx_w),
    .line_o      (line_w)
  );

  generate
    for (genvar b = 0; b < LINE_WORDS; b++) begin : g_bank
      refill_bank #(
        .WORD_W     (WORD_W),
        .LINE_AW    (LINE_AW),
        .LANE       (b),
        .LINE_WORDS (LINE_WORDS)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_line_i (line_w),
        .rd_data_o (lane_data_w[b*WORD_W +: WORD_W])
      );
    end
  endgenerate

  refill_beat #(
    .LINE_WORDS (LINE_WORDS),
    .WORD_W     (WORD_W),
    .WPB        (WPB),
    .BEAT_W     (BEAT_W)
  ) u_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_end_i  (xfer_end_w),
    .last_i      (last_w),
    .beat_idx_i  (beat_idx_w),
    .lane_data_i (lane_data_w),
    .beat_vld_o  (beat_vld_o),
    .beat_mask_o (beat_mask_o),
    .beat_data_o (beat_data_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
  parameter int unsigned LINE_WORDS = 4,
  parameter int unsigned WPB        = 1,
  parameter int unsigned PENALTY    = 20,
  parameter int unsigned LINE_AW    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  beat_vld_o,
  input logic [LINE_WORDS-1:0] beat_mask_o,
  input logic                  accept_evt,
  input logic [LINE_AW-1:0]    line_q
);

  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          lat_cnt <= '0;
    else if (accept_evt) lat_cnt <= '0;
    else if (busy_o)     lat_cnt <= lat_cnt + 1'b1;
  end

  // R3 R4 R5 R6
  penalty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt == 16'(PENALTY)));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy_o);

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10
  done_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> beat_vld_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  beat_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o |-> ($countones(beat_mask_o) == WPB));

  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(line_q));

endmodule

bind refill_engine refill_engine_chk #(
  .LINE_WORDS (LINE_WORDS),
  .WPB        (WPB),
  .PENALTY    (PENALTY),
  .LINE_AW    (LINE_AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .beat_vld_o  (beat_vld_o),
  .beat_mask_o (beat_mask_o),
  .accept_evt  (accept_w),
  .line_q      (line_w)
);

// File: tb/refill_engine_tb.sv
module refill_engine_tb;
  import refill_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] blk_addr_i = '0;

  logic         busy   [4];
  logic         vld    [4];
  logic [3:0]   mask   [4];
  logic [127:0] data   [4];
  logic         done   [4];

  int tests = 0;
  int fails = 0;
  bit chk_en = 1'b0;
  string phase_tag = "R2";

  // index 0 narrow, 1 two-wide, 2 four-wide, 3 interleaved
  int    PEN [4]      = '{65, 33, 17, 20};
  string DONE_TAG [4] = '{"R3", "R4", "R5", "R6"};

  bit m_act  [4];
  int m_n    [4];
  int m_addr [4];

  always #2 clk = ~clk;

  refill_engine #(.ORG(ORG_NARROW1)) u_dut_n1 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .busy_o(busy[0]), .beat_vld_o(vld[0]), .beat_mask_o(mask[0]),
    .beat_data_o(data[0]), .done_o(done[0]));

  refill_engine #(.ORG(ORG_WIDE2)) u_dut_w2 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .busy_o(busy[1]), .beat_vld_o(vld[1]), .beat_mask_o(mask[1]),
    .beat_data_o(data[1]), .done_o(done[1]));

  refill_engine #(.ORG(ORG_WIDE4)) u_dut_w4 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .busy_o(busy[2]), .beat_vld_o(vld[2]), .beat_mask_o(mask[2]),
    .beat_data_o(data[2]), .done_o(done[2]));

  refill_engine #(.ORG(ORG_IL4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
    .busy_o(busy[3]), .beat_vld_o(vld[3]), .beat_mask_o(mask[3]),
    .beat_data_o(data[3]), .done_o(done[3]));

  // edge after acceptance at which word i arrives (R3-style timing, R7, R6)
  function automatic int arrive(int org, int i);
    case (org)
      0:       return 1 + (i + 1) * 16;
      1:       return 1 + (i / 2 + 1) * 16;
      2:       return 17;
      default: return 16 + (i + 1);
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", tag, phase_tag, what, act, exp);
    end
  endtask

  // behavioural reference: one counter per copy, advanced on every edge
  always @(posedge clk) begin
    for (int j = 0; j < 4; j++) begin
      if (!rst_n) begin
        m_act[j] = 1'b0;
        m_n[j]   = 0;
      end else if (m_act[j] && m_n[j] < PEN[j]) begin
        m_n[j] = m_n[j] + 1;
      end else begin
        m_act[j] = 1'b0;
        if (start_i) begin   // R11 accept in done cycle, R2 accept when idle
          m_act[j]  = 1'b1;
          m_n[j]    = 0;
          m_addr[j] = int'(blk_addr_i);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      for (int j = 0; j < 4; j++) begin
        logic [3:0]   emask;
        logic [127:0] edata;
        bit ebusy, edone;
        emask = '0;
        edata = '0;
        if (m_act[j] && m_n[j] > 0) begin
          for (int i = 0; i < 4; i++) begin
            if (arrive(j, i) == m_n[j]) begin
              emask[i] = 1'b1;
              edata[i*32 +: 32] = 32'h5A5A_0000 + 32'((m_addr[j] % 16) * 4 + i);
            end
          end
        end
        ebusy = m_act[j] && (m_n[j] < PEN[j]);
        edone = m_act[j] && (m_n[j] == PEN[j]);
        check(busy[j] == ebusy, "R2", $sformatf("busy org%0d", j), 128'(busy[j]), 128'(ebusy));
        check(done[j] == edone, DONE_TAG[j], $sformatf("done org%0d", j), 128'(done[j]), 128'(edone));
        check(mask[j] == emask, (j == 3) ? "R6" : "R7", $sformatf("mask org%0d", j), 128'(mask[j]), 128'(emask));
        check(vld[j] == (emask != 0), "R7", $sformatf("vld org%0d", j), 128'(vld[j]), 128'(emask != 0));
        check(data[j] == edata, "R8", $sformatf("data org%0d", j), data[j], edata);
        if (edone)
          check(vld[j] == 1'b1, "R10", $sformatf("last beat org%0d", j), 128'(vld[j]), 128'(1));
      end
    end
  end

  task automatic pulse(logic [7:0] a);
    @(negedge clk);
    start_i    = 1'b1;
    blk_addr_i = a;
    @(negedge clk);
    start_i    = 1'b0;
    blk_addr_i = 8'hEE;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    for (int j = 0; j < 4; j++)
      check(!busy[j] && !vld[j] && !done[j] && mask[j] == 0 && data[j] == 0,
            "R1", "reset outputs", {busy[j], vld[j], done[j], mask[j]}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: still quiet in the first cycle after reset
    for (int j = 0; j < 4; j++)
      check(!busy[j] && !vld[j] && !done[j] && mask[j] == 0,
            "R1", "post-reset outputs", {busy[j], vld[j], done[j], mask[j]}, '0);
    chk_en = 1'b1;

    phase_tag = "R2";
    pulse(8'd3);
    repeat (75) @(negedge clk);

    // R8 address wrap and R9 ignored start while busy
    phase_tag = "R9";
    pulse(8'd21);
    repeat (8) @(negedge clk);
    pulse(8'd9);
    repeat (75) @(negedge clk);

    // R11 start held high: each copy re-accepts in its own done cycle
    phase_tag = "R11";
    @(negedge clk);
    start_i = 1'b1;
    for (int c = 0; c < 300; c++) begin
      blk_addr_i = 8'(c * 7 + 2);
      @(negedge clk);
    end
    start_i = 1'b0;
    repeat (75) @(negedge clk);

    phase_tag = "R8";
    pulse(8'd15);
    repeat (75) @(negedge clk);
    pulse(8'd240);
    repeat (75) @(negedge clk);

    chk_en = 1'b0;
    summary();
    $finish;
  end

endmodule